// File: doc/BRIEF.md
# Precise Exception Controller

This block decides, cycle by cycle, whether a five-stage in-order pipeline must abandon its current flow and enter an exception handler. Two fault sources report to it: the decode stage raises a flag when it sees an opcode it cannot execute, and the execute stage raises a flag when an arithmetic result overflows. Each flag comes with the address of the instruction that raised it. When either is present, the block picks the older instruction and flushes the stage registers that hold that instruction and every younger one. If the fault is in execute, it also stops that instruction from writing its destination register. In the same cycle it issues a redirect to the handler entry.

The handler entry is chosen by a mode input. In fixed mode every fault goes to one shared entry. In vectored mode each cause has its own entry, placed at a regular stride above a vector base. The faulting instruction's address plus one instruction length is latched into an exception-PC register, and the cause code is latched alongside it, so the handler can find and classify the fault. A branch redirect from the pipeline passes through unchanged when no fault is present. A fault always takes precedence over a branch in the same cycle.

Top module: `trap_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after its release, the exception-PC and cause outputs read zero.
- R2: An overflow flag from execute drives all three flush outputs (fetch/decode, decode/execute, execute/memory), the write-inhibit output and the redirect valid output high in the same cycle.
- R3: An undefined-opcode flag from decode, with no overflow flag, flushes the fetch/decode and decode/execute registers only. The execute/memory flush and the write-inhibit stay low, so the older instruction in execute completes.
- R4: When both flags are high in one cycle, the overflow is the one taken, because its instruction is older. Cause reads 1 and the exception PC is derived from the execute-stage address.
- R5: The cycle after a fault is taken, the exception-PC output equals the faulting instruction's address plus 4. The cause output reads 0 for an undefined opcode and 1 for an overflow.
- R6: With the mode input low (fixed), the redirect address for any fault is 0x80000180.
- R7: With the mode input high (vectored), the redirect address is 0xC0000000 plus 0x20 times the cause code. This gives 0xC0000000 for an undefined opcode and 0xC0000020 for an overflow.
- R8: A fault in the same cycle as a branch redirect replaces the branch target with the handler address. A branch with no fault passes through as a redirect to the branch target, raising no flush and no inhibit.
- R9: In cycles with no fault, the exception-PC and cause registers keep their values, even when a branch redirect is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| vec_mode_i | input | 1 | 1 selects per-cause vectored entries, 0 selects the single fixed entry |
| id_undef_i | input | 1 | Decode stage holds an undefined opcode |
| id_pc_i | input | 32 | Address of the instruction in decode |
| ex_ovf_i | input | 1 | Execute stage produced an arithmetic overflow |
| ex_pc_i | input | 32 | Address of the instruction in execute |
| br_take_i | input | 1 | Pipeline requests a branch redirect this cycle |
| br_target_i | input | 32 | Branch target address |
| flush_ifid_o | output | 1 | Clear the fetch/decode stage register |
| flush_idex_o | output | 1 | Clear the decode/execute stage register |
| flush_exmem_o | output | 1 | Clear the execute/memory stage register |
| wr_inhibit_o | output | 1 | Block the register write of the instruction in execute |
| redir_valid_o | output | 1 | Redirect strobe for the fetch stage |
| redir_pc_o | output | 32 | Redirect address |
| epc_o | output | 32 | Exception PC register contents |
| cause_o | output | 1 | Cause register contents |

## Verification
The hardest situation to reach is two faults raised together, combined with a branch and with either handler mode. All four conditions must line up in one cycle, and the result is only correct if the older fault wins on every output at once. Random stimulus gives each fault flag and the branch a sizeable probability on every cycle, so such collisions recur many times in both modes. Directed cycles add the exact double-fault-with-branch case in each mode, together with a register-retention check right after a fault.

// File: rtl/trap_pkg.sv
package trap_pkg;
   // Cause codes; the vectored entry offset depends on these values.
   typedef enum logic {
      CAUSE_UNDEF = 1'b0,
      CAUSE_OVF   = 1'b1
   } trap_cause_e;
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter #(
   parameter int PC_W = 32
) (
   input  logic             id_undef_i,
   input  logic [PC_W-1:0]  id_pc_i,
   input  logic             ex_ovf_i,
   input  logic [PC_W-1:0]  ex_pc_i,
   output logic             take_o,
   output trap_pkg::trap_cause_e cause_o,
   output logic [PC_W-1:0]  fault_pc_o,
   output logic             fl_ifid_o,
   output logic             fl_idex_o,
   output logic             fl_exmem_o,
   output logic             inhibit_o
);
   import trap_pkg::*;

   // Execute holds the older instruction, so it wins.
   always_comb begin
      take_o     = id_undef_i | ex_ovf_i;
      cause_o    = CAUSE_UNDEF;
      fault_pc_o = id_pc_i;
      fl_ifid_o  = 1'b0;
      fl_idex_o  = 1'b0;
      fl_exmem_o = 1'b0;
      inhibit_o  = 1'b0;
      if (ex_ovf_i) begin
         cause_o    = CAUSE_OVF;
         fault_pc_o = ex_pc_i;
         fl_ifid_o  = 1'b1;
         fl_idex_o  = 1'b1;
         fl_exmem_o = 1'b1;
         inhibit_o  = 1'b1;
      end else if (id_undef_i) begin
         fl_ifid_o  = 1'b1;
         fl_idex_o  = 1'b1;
      end
   end
endmodule

// File: rtl/trap_target.sv
module trap_target #(
   parameter int          PC_W       = 32,
   parameter bit          VEC_EN     = 1'b1,
   parameter logic [31:0] FIX_ENTRY  = 32'h8000_0180,
   parameter logic [31:0] VEC_BASE   = 32'hC000_0000,
   parameter int          STRIDE_LG2 = 5
) (
   input  logic                  vec_mode_i,
   input  trap_pkg::trap_cause_e cause_i,
   output logic [PC_W-1:0]       entry_o
);
   localparam logic [PC_W-1:0] FIX_P  = PC_W'(FIX_ENTRY);
   localparam logic [PC_W-1:0] BASE_P = PC_W'(VEC_BASE);

   generate
      if (VEC_EN) begin : g_vec
         logic [PC_W-1:0] offs;
         assign offs    = PC_W'(cause_i) << STRIDE_LG2;
         assign entry_o = vec_mode_i ? (BASE_P + offs) : FIX_P;
      end else begin : g_fix
         assign entry_o = FIX_P;
      end
   endgenerate
endmodule

// File: rtl/trap_regs.sv
module trap_regs #(
   parameter int PC_W        = 32,
   parameter int INSTR_BYTES = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  take_i,
   input  trap_pkg::trap_cause_e cause_i,
   input  logic [PC_W-1:0]       fault_pc_i,
   output logic [PC_W-1:0]       epc_o,
   output logic                  cause_o
);
   localparam logic [PC_W-1:0] STEP = PC_W'(INSTR_BYTES);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         epc_o   <= '0;
         cause_o <= 1'b0;
      end else if (take_i) begin
         epc_o   <= fault_pc_i + STEP;
         cause_o <= cause_i;
      end
   end
endmodule

// File: rtl/trap_unit.sv
module trap_unit #(
   parameter int          PC_W        = 32,
   parameter int          INSTR_BYTES = 4,
   parameter bit          VEC_EN      = 1'b1,
   parameter logic [31:0] FIX_ENTRY   = 32'h8000_0180,
   parameter logic [31:0] VEC_BASE    = 32'hC000_0000,
   parameter int          STRIDE_LG2  = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            vec_mode_i,
   input  logic            id_undef_i,
   input  logic [PC_W-1:0] id_pc_i,
   input  logic            ex_ovf_i,
   input  logic [PC_W-1:0] ex_pc_i,
   input  logic            br_take_i,
   input  logic [PC_W-1:0] br_target_i,
   output logic            flush_ifid_o,
   output logic            flush_idex_o,
   output logic            flush_exmem_o,
   output logic            wr_inhibit_o,
   output logic            redir_valid_o,
   output logic [PC_W-1:0] redir_pc_o,
   output logic [PC_W-1:0] epc_o,
   output logic            cause_o
);
   if (PC_W < 8 || PC_W > 64) begin : g_bad_pcw
      $error("trap_unit: PC_W out of range");
   end
   if (STRIDE_LG2 < 2 || STRIDE_LG2 >= PC_W) begin : g_bad_stride
      $error("trap_unit: STRIDE_LG2 out of range");
   end
   if (INSTR_BYTES < 1) begin : g_bad_step
      $error("trap_unit: INSTR_BYTES must be positive");
   end

   logic                  take;
   trap_pkg::trap_cause_e sel_cause;
   logic [PC_W-1:0]       fault_pc;
   logic [PC_W-1:0]       entry;

   trap_arbiter #(.PC_W(PC_W)) u_arb (
      .id_undef_i (id_undef_i),
      .id_pc_i    (id_pc_i),
      .ex_ovf_i   (ex_ovf_i),
      .ex_pc_i    (ex_pc_i),
      .take_o     (take),
      .cause_o    (sel_cause),
      .fault_pc_o (fault_pc),
      .fl_ifid_o  (flush_ifid_o),
      .fl_idex_o  (flush_idex_o),
      .fl_exmem_o (flush_exmem_o),
      .inhibit_o  (wr_inhibit_o)
   );

   trap_target #(
      .PC_W(PC_W), .VEC_EN(VEC_EN), .FIX_ENTRY(FIX_ENTRY),
      .VEC_BASE(VEC_BASE), .STRIDE_LG2(STRIDE_LG2)
   ) u_tgt (
      .vec_mode_i (vec_mode_i),
      .cause_i    (sel_cause),
      .entry_o    (entry)
   );

   trap_regs #(.PC_W(PC_W), .INSTR_BYTES(INSTR_BYTES)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .take_i     (take),
      .cause_i    (sel_cause),
      .fault_pc_i (fault_pc),
      .epc_o      (epc_o),
      .cause_o    (cause_o)
   );

   // A fault replaces any branch redirect of the same cycle.
   assign redir_valid_o = take | br_take_i;
   assign redir_pc_o    = take ? entry : br_target_i;
endmodule

// File: rtl/trap_unit_chk.sv
module trap_unit_chk #(
   parameter int          PC_W        = 32,
   parameter int          INSTR_BYTES = 4,
   parameter logic [31:0] FIX_ENTRY   = 32'h8000_0180
) (
   input logic            clk,
   input logic            rst_n,
   input logic            vec_mode_i,
   input logic            id_undef_i,
   input logic [PC_W-1:0] id_pc_i,
   input logic            ex_ovf_i,
   input logic [PC_W-1:0] ex_pc_i,
   input logic            flush_ifid_o,
   input logic            flush_idex_o,
   input logic            flush_exmem_o,
   input logic            wr_inhibit_o,
   input logic            redir_valid_o,
   input logic [PC_W-1:0] redir_pc_o,
   input logic [PC_W-1:0] epc_o,
   input logic            cause_o
);
   localparam logic [PC_W-1:0] STEP  = PC_W'(INSTR_BYTES);
   localparam logic [PC_W-1:0] FIX_P = PC_W'(FIX_ENTRY);

   AST_OVF_FLUSH_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      ex_ovf_i |-> (flush_ifid_o && flush_idex_o && flush_exmem_o && wr_inhibit_o && redir_valid_o)); // R2
   AST_UNDEF_KEEP_EX: assert property (@(posedge clk) disable iff (!rst_n)
      (id_undef_i && !ex_ovf_i) |-> (flush_ifid_o && flush_idex_o && !flush_exmem_o && !wr_inhibit_o)); // R3
   AST_OLDEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ex_ovf_i |=> cause_o); // R4
   AST_EPC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (id_undef_i || ex_ovf_i) |=> epc_o == (($past(ex_ovf_i) ? $past(ex_pc_i) : $past(id_pc_i)) + STEP)); // R5
   AST_FIXED_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      ((id_undef_i || ex_ovf_i) && !vec_mode_i) |-> redir_pc_o == FIX_P); // R6
   AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(id_undef_i || ex_ovf_i) |=> ($stable(epc_o) && $stable(cause_o))); // R9
endmodule

bind trap_unit trap_unit_chk #(
   .PC_W(PC_W), .INSTR_BYTES(INSTR_BYTES), .FIX_ENTRY(FIX_ENTRY)
) u_chk (
   .clk(clk), .rst_n(rst_n), .vec_mode_i(vec_mode_i),
   .id_undef_i(id_undef_i), .id_pc_i(id_pc_i),
   .ex_ovf_i(ex_ovf_i), .ex_pc_i(ex_pc_i),
   .flush_ifid_o(flush_ifid_o), .flush_idex_o(flush_idex_o),
   .flush_exmem_o(flush_exmem_o), .wr_inhibit_o(wr_inhibit_o),
   .redir_valid_o(redir_valid_o), .redir_pc_o(redir_pc_o),
   .epc_o(epc_o), .cause_o(cause_o)
);

// File: tb/tb_trap_unit.sv
module tb_trap_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        vec_mode_i = 1'b0;
   logic        id_undef_i = 1'b0;
   logic [31:0] id_pc_i = '0;
   logic        ex_ovf_i = 1'b0;
   logic [31:0] ex_pc_i = '0;
   logic        br_take_i = 1'b0;
   logic [31:0] br_target_i = '0;
   logic        flush_ifid_o, flush_idex_o, flush_exmem_o, wr_inhibit_o;
   logic        redir_valid_o, cause_o;
   logic [31:0] redir_pc_o, epc_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [31:0] m_epc;
   logic        m_cause;

   always #10 clk = ~clk;

   trap_unit dut (
      .clk(clk), .rst_n(rst_n), .vec_mode_i(vec_mode_i),
      .id_undef_i(id_undef_i), .id_pc_i(id_pc_i),
      .ex_ovf_i(ex_ovf_i), .ex_pc_i(ex_pc_i),
      .br_take_i(br_take_i), .br_target_i(br_target_i),
      .flush_ifid_o(flush_ifid_o), .flush_idex_o(flush_idex_o),
      .flush_exmem_o(flush_exmem_o), .wr_inhibit_o(wr_inhibit_o),
      .redir_valid_o(redir_valid_o), .redir_pc_o(redir_pc_o),
      .epc_o(epc_o), .cause_o(cause_o)
   );

   function automatic logic [31:0] exp_entry(logic vec, logic ovf);
      if (!vec) return 32'h8000_0180;
      return 32'hC000_0000 + (ovf ? 32'h20 : 32'h0);
   endfunction

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   // One cycle: drive at negedge, check same-cycle outputs, then registers after the edge.
   task automatic step(logic vec, logic und, logic [31:0] ipc, logic ovf,
                       logic [31:0] epc_in, logic br, logic [31:0] bt);
      logic exc;
      @(negedge clk);
      vec_mode_i = vec; id_undef_i = und; id_pc_i = ipc;
      ex_ovf_i = ovf; ex_pc_i = epc_in; br_take_i = br; br_target_i = bt;
      exc = und | ovf;
      #2;
      chk(ovf ? "R2" : "R3", "flush_ifid", 32'(flush_ifid_o), 32'(exc));
      chk(ovf ? "R2" : "R3", "flush_idex", 32'(flush_idex_o), 32'(exc));
      chk(ovf ? "R2" : (und ? "R3" : "R8"), "flush_exmem", 32'(flush_exmem_o), 32'(ovf));
      chk(ovf ? "R2" : (und ? "R3" : "R8"), "wr_inhibit", 32'(wr_inhibit_o), 32'(ovf));
      chk("R8", "redir_valid", 32'(redir_valid_o), 32'(exc | br));
      if (exc)
         chk(vec ? "R7" : "R6", "redir_pc", redir_pc_o, exp_entry(vec, ovf));
      else if (br)
         chk("R8", "redir_pc", redir_pc_o, bt);
      if (exc) begin
         m_epc   = (ovf ? epc_in : ipc) + 32'd4;
         m_cause = ovf;
      end
      @(posedge clk);
      #1;
      chk(exc ? ((und && ovf) ? "R4" : "R5") : "R9", "epc", epc_o, m_epc);
      chk(exc ? ((und && ovf) ? "R4" : "R5") : "R9", "cause", 32'(cause_o), 32'(m_cause));
   endtask

   initial begin
      #3_000_000;
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      m_epc = '0; m_cause = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      chk("R1", "epc in reset", epc_o, 32'h0);
      chk("R1", "cause in reset", 32'(cause_o), 32'h0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      chk("R1", "epc after release", epc_o, 32'h0);
      chk("R1", "cause after release", 32'(cause_o), 32'h0);

      // Directed corner cases
      step(1'b0, 1'b1, 32'h0000_0040, 1'b0, 32'h0, 1'b0, 32'h0);        // R3 R5 R6
      step(1'b0, 1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 32'h0000_1000);        // R8 R9 branch only
      step(1'b1, 1'b0, 32'h0, 1'b1, 32'h0000_004C, 1'b0, 32'h0);        // R2 R7
      step(1'b1, 1'b1, 32'h0000_0050, 1'b1, 32'h0000_004C, 1'b1, 32'h2000); // R4 R8
      step(1'b0, 1'b1, 32'h0000_0050, 1'b1, 32'h0000_004C, 1'b1, 32'h2000); // R4 R6
      step(1'b1, 1'b1, 32'hFFFF_FFFC, 1'b0, 32'h0, 1'b0, 32'h0);        // R5 wrap, R7 cause 0
      step(1'b1, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0);                // R9 idle

      // Random traffic
      for (int i = 0; i < 600; i++) begin
         step($urandom_range(0, 1) == 1,
              $urandom_range(0, 3) == 0, $urandom() & 32'hFFFF_FFFC,
              $urandom_range(0, 3) == 0, $urandom() & 32'hFFFF_FFFC,
              $urandom_range(0, 2) == 0, $urandom() & 32'hFFFF_FFFC);
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule